// File: doc/BRIEF.md
# Framing Pattern Loss Monitor

This block supervises the framing bits that a T1 receiver recovers from an extended-superframe stream. Each recovered framing bit arrives with a one-cycle strobe. The block checks each bit against the framing pattern it expects at that position in the current six-bit group. When a group closes with too many mismatches, the block raises a loss-of-frame event. It sends the framer a request to resynchronize and adds one to an event tally that a host can read and clear.

After an event the block stops comparing. It ignores every framing bit until the framer reports that it has realigned. It then starts a fresh group. A superframe-boundary marker that arrives with a strobed bit forces that bit to be the first of a new group, and any partial group is dropped. The framer's search and realignment logic sits outside this block.

Top module: `framing_loss_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `lof_pulse` and `resync_req` are 0 and `lof_count` is 0.
- R2: A bit is sampled only in cycles where `fbit_valid` is 1. The six bits of a group are compared in arrival order against the expected values 0, 0, 1, 0, 1, 1. When the sixth bit of a group brings the mismatch total to 2 or more, `lof_pulse` is 1 for exactly the one cycle after that bit's strobe cycle.
- R3: A group that closes with 0 or 1 mismatches raises no event, and the counter does not change.
- R4: A strobed bit that arrives with `sf_start` = 1 becomes the first bit of a new group. The mismatches of an unfinished group are discarded.
- R5: `resync_req` rises in the same cycle as `lof_pulse`. It stays at 1 until `realign_done` is sampled at 1, and it is 0 from the next cycle on.
- R6: While `resync_req` is 1, strobed bits raise no event. Once the request is released, comparison restarts at the first group position, even when no `sf_start` marker is given.
- R7: Each event increments the 16-bit `lof_count` by exactly one. The count is visible in the same cycle as `lof_pulse`.
- R8: The counter saturates at all ones and never wraps to zero.
- R9: `host_clr` = 1 sets `lof_count` to 0 on the next cycle. If an event occurs in the same cycle, the clear wins. The event still pulses and requests resynchronization.
- R10: `realign_done` has no effect while no request is pending. A group that is in progress continues at its current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fbit_valid | input | 1 | Strobe marking a recovered framing bit |
| fbit | input | 1 | Value of the recovered framing bit |
| sf_start | input | 1 | Marks the strobed bit as the first of a superframe group |
| realign_done | input | 1 | Framer reports it has realigned |
| host_clr | input | 1 | Synchronous clear of the event counter |
| lof_pulse | output | 1 | One-cycle loss-of-frame event |
| resync_req | output | 1 | Resynchronization request to the framer |
| lof_count | output | 16 | Saturating loss-of-frame event count |

## Verification
Three situations are hard to reach from the ports:
- **Saturation.** Filling the 16-bit counter would take far longer than the run allows. The bench therefore drives a second instance with a 3-bit counter from the same stimulus, and nine failing groups push that instance past its ceiling.
- **Clear and event together.** The stimulus asserts `host_clr` in the exact strobe cycle of a failing sixth bit.
- **Suspension and restart.** A full group of wrong bits is sent while a request is pending. After release, unmarked groups are sent, which exposes the group position the design restarts from.

// File: rtl/flm_pkg.sv
package flm_pkg;
   typedef enum logic {
      FLM_TRACK = 1'b0,
      FLM_HOLD  = 1'b1
   } flm_state_e;

   localparam int FLM_DEF_GROUP = 6;
   localparam int FLM_DEF_LIMIT = 2;
endpackage

// File: rtl/flm_group_eval.sv
module flm_group_eval #(
   parameter int                   GROUP_LEN = 6,
   parameter int                   ERR_LIMIT = 2,
   parameter logic [GROUP_LEN-1:0] PATTERN   = 6'b110100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   input  logic grp_start,
   input  logic flush,
   output logic grp_fail
);
   localparam int POS_W = $clog2(GROUP_LEN);
   localparam int ERR_W = $clog2(GROUP_LEN + 1);

   logic [POS_W-1:0]     pos_q, pos_eff;
   logic [ERR_W-1:0]     err_q, err_eff, err_next;
   logic [GROUP_LEN-1:0] mism_vec;
   logic                 miss, last;

   assign pos_eff = grp_start ? '0 : pos_q;
   assign err_eff = grp_start ? '0 : err_q;

   // one comparator per group position, selected by the current position
   for (genvar g = 0; g < GROUP_LEN; g++) begin : g_pos
      assign mism_vec[g] = (pos_eff == POS_W'(g)) && (bit_in != PATTERN[g]);
   end

   assign miss     = |mism_vec;
   assign err_next = err_eff + ERR_W'(miss);
   assign last     = (pos_eff == POS_W'(GROUP_LEN - 1));
   assign grp_fail = bit_valid && last && (err_next >= ERR_W'(ERR_LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         pos_q <= '0;
         err_q <= '0;
      end else if (bit_valid) begin
         if (last) begin
            pos_q <= '0;
            err_q <= '0;
         end else begin
            pos_q <= pos_eff + POS_W'(1);
            err_q <= err_next;
         end
      end
   end
endmodule

// File: rtl/flm_resync_ctrl.sv
module flm_resync_ctrl
   import flm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic realign_done,
   output logic resync_req
);
   flm_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FLM_TRACK;
      end else begin
         unique case (state_q)
            FLM_TRACK: if (set_req)      state_q <= FLM_HOLD;
            FLM_HOLD:  if (realign_done) state_q <= FLM_TRACK;
            default:                     state_q <= FLM_TRACK;
         endcase
      end
   end

   assign resync_req = (state_q == FLM_HOLD);
endmodule

// File: rtl/flm_sat_counter.sv
module flm_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/framing_loss_monitor.sv
module framing_loss_monitor #(
   parameter int                   CNT_W     = 16,
   parameter int                   GROUP_LEN = flm_pkg::FLM_DEF_GROUP,
   parameter int                   ERR_LIMIT = flm_pkg::FLM_DEF_LIMIT,
   parameter logic [GROUP_LEN-1:0] PATTERN   = 6'b110100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fbit_valid,
   input  logic             fbit,
   input  logic             sf_start,
   input  logic             realign_done,
   input  logic             host_clr,
   output logic             lof_pulse,
   output logic             resync_req,
   output logic [CNT_W-1:0] lof_count
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("framing_loss_monitor: CNT_W must be at least 1");
   end
   if (GROUP_LEN < 2) begin : g_bad_len
      $error("framing_loss_monitor: GROUP_LEN must be at least 2");
   end
   if (ERR_LIMIT < 1 || ERR_LIMIT > GROUP_LEN) begin : g_bad_lim
      $error("framing_loss_monitor: ERR_LIMIT out of range");
   end

   logic bit_ok;
   logic grp_fail;
   logic pulse_q;

   // bits are ignored while a resync request is pending
   assign bit_ok = fbit_valid && !resync_req;

   flm_group_eval #(
      .GROUP_LEN (GROUP_LEN),
      .ERR_LIMIT (ERR_LIMIT),
      .PATTERN   (PATTERN)
   ) u_eval (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_ok),
      .bit_in    (fbit),
      .grp_start (sf_start),
      .flush     (resync_req),
      .grp_fail  (grp_fail)
   );

   flm_resync_ctrl u_resync (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_req      (grp_fail),
      .realign_done (realign_done),
      .resync_req   (resync_req)
   );

   flm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (host_clr),
      .inc   (grp_fail),
      .count (lof_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= grp_fail;
   end

   assign lof_pulse = pulse_q;
endmodule

// File: rtl/flm_checker.sv
module flm_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_clr,
   input logic             realign_done,
   input logic             lof_pulse,
   input logic             resync_req,
   input logic [CNT_W-1:0] lof_count
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lof_pulse |=> !lof_pulse);

   assert_req_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lof_pulse |-> resync_req);

   assert_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resync_req) |-> lof_pulse);

   assert_req_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (resync_req && realign_done) |=> !resync_req);

   assert_suspended_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resync_req |=> !lof_pulse);

   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lof_pulse && !$past(host_clr) && ($past(lof_count) != MAXV))
         |-> (lof_count == $past(lof_count) + CNT_W'(1)));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((lof_count == MAXV) && !host_clr) |=> (lof_count == MAXV));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr |=> (lof_count == '0));
endmodule

bind framing_loss_monitor flm_checker #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_clr     (host_clr),
   .realign_done (realign_done),
   .lof_pulse    (lof_pulse),
   .resync_req   (resync_req),
   .lof_count    (lof_count)
);

// File: tb/sim_framing_loss_monitor.sv
`timescale 1ns/1ps
module sim_framing_loss_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fbit_valid = 1'b0;
   logic        fbit = 1'b0;
   logic        sf_start = 1'b0;
   logic        realign_done = 1'b0;
   logic        host_clr = 1'b0;
   logic        lof_pulse, resync_req;
   logic [15:0] lof_count;
   logic        lof_pulse1, resync_req1;
   logic [2:0]  lof_count1;

   int n_chk  = 0;
   int n_fail = 0;
   int exp_cnt  = 0;
   int exp_cnt1 = 0;
   bit done = 0;

   // bit k of each entry = k-th arriving bit; bit 6 = an event is expected
   localparam logic [6:0] VEC [8] = '{
      7'b0_110100, 7'b0_110101, 7'b0_010100, 7'b1_110111,
      7'b1_010000, 7'b1_001011, 7'b0_111100, 7'b1_000100 };

   always #2.5 clk = ~clk;

   framing_loss_monitor u0 (
      .clk(clk), .rst_n(rst_n), .fbit_valid(fbit_valid), .fbit(fbit),
      .sf_start(sf_start), .realign_done(realign_done), .host_clr(host_clr),
      .lof_pulse(lof_pulse), .resync_req(resync_req), .lof_count(lof_count));

   framing_loss_monitor #(.CNT_W(3)) u1 (
      .clk(clk), .rst_n(rst_n), .fbit_valid(fbit_valid), .fbit(fbit),
      .sf_start(sf_start), .realign_done(realign_done), .host_clr(host_clr),
      .lof_pulse(lof_pulse1), .resync_req(resync_req1), .lof_count(lof_count1));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, input logic sf, input logic clr);
      @(negedge clk);
      fbit_valid = 1'b1; fbit = b; sf_start = sf; host_clr = clr;
      @(negedge clk);
      fbit_valid = 1'b0; sf_start = 1'b0; host_clr = 1'b0;
   endtask

   task automatic send_group(input logic [5:0] d, input logic mark);
      for (int k = 0; k < 6; k++) send_bit(d[k], mark && (k == 0), 1'b0);
   endtask

   task automatic realign();
      @(negedge clk); realign_done = 1'b1;
      @(negedge clk); realign_done = 1'b0;
   endtask

   task automatic note_event();
      exp_cnt++;
      if (exp_cnt1 < 7) exp_cnt1++;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 pulse in reset", lof_pulse, 0);
      chk("R1 req in reset", resync_req, 0);
      chk("R1 count in reset", lof_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pulse after reset", lof_pulse, 0);
      chk("R1 count after reset", lof_count, 0);

      // table walk: R2 / R3 / R5 / R7
      for (int i = 0; i < 8; i++) begin
         send_group(VEC[i][5:0], 1'b1);
         chk(VEC[i][6] ? "R2 event pulse" : "R3 no event", lof_pulse, VEC[i][6]);
         chk("R5 req with event", resync_req, VEC[i][6]);
         if (VEC[i][6]) note_event();
         chk("R7 count", lof_count, exp_cnt);
         @(negedge clk);
         chk("R2 pulse one cycle", lof_pulse, 0);
         if (VEC[i][6]) begin
            chk("R5 req held", resync_req, 1);
            realign();
            chk("R5 req released", resync_req, 0);
         end
      end

      // R6: suspension, then restart at position one without marker
      send_group(6'b111111, 1'b1);
      note_event();
      chk("R6 setup event", lof_pulse, 1);
      send_group(6'b001011, 1'b1);
      chk("R6 no pulse while pending", lof_pulse, 0);
      chk("R6 count frozen", lof_count, exp_cnt);
      chk("R6 req still pending", resync_req, 1);
      realign();
      send_group(6'b110100, 1'b0);
      chk("R6 restart clean group", lof_pulse, 0);
      send_group(6'b110111, 1'b0);
      chk("R6 restart bad group", lof_pulse, 1);
      note_event();
      chk("R6 count", lof_count, exp_cnt);
      realign();

      // R4: marker mid-group discards partial errors
      send_bit(1'b1, 1'b1, 1'b0);
      send_bit(1'b1, 1'b0, 1'b0);
      send_bit(1'b1, 1'b0, 1'b0);
      send_group(6'b110100, 1'b1);
      chk("R4 partial discarded", lof_pulse, 0);
      chk("R4 count", lof_count, exp_cnt);
      send_bit(1'b0, 1'b1, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_group(6'b110101, 1'b1);
      chk("R4 restart single error", lof_pulse, 0);

      // R10: realign with nothing pending leaves the group in progress
      send_bit(1'b0, 1'b1, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b1, 1'b0, 1'b0);
      realign();
      chk("R10 req stays low", resync_req, 0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      chk("R10 group continued", lof_pulse, 1);
      note_event();
      chk("R10 count", lof_count, exp_cnt);
      realign();

      // R9: clear alone, then clear together with an event
      @(negedge clk); host_clr = 1'b1;
      @(negedge clk); host_clr = 1'b0;
      exp_cnt = 0; exp_cnt1 = 0;
      chk("R9 clear", lof_count, 0);
      chk("R9 clear small", lof_count1, 0);
      for (int k = 0; k < 5; k++) send_bit(1'b1, k == 0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b1);
      chk("R9 pulse with clear", lof_pulse, 1);
      chk("R9 clear wins", lof_count, 0);
      chk("R9 req with clear", resync_req, 1);
      realign();

      // R8: saturation of the narrow instance
      for (int j = 0; j < 9; j++) begin
         send_group(6'b001011, 1'b1);
         note_event();
         realign();
      end
      chk("R8 saturated", lof_count1, 7);
      chk("R7 wide count", lof_count, exp_cnt);
      send_group(6'b001011, 1'b1);
      note_event();
      chk("R8 no wrap", lof_count1, 7);
      chk("R7 wide count 16 bit", lof_count, exp_cnt);
      realign();

      done = 1;
      summary();
      $finish;
   end
endmodule